// File: doc/BRIEF.md
# Block-Transfer Configuration Register Slave

This block is a two-wire serial slave that gives a host access to a small bank of byte-wide configuration registers. It runs on a fast system clock and oversamples the serial clock and data lines. It finds start and stop conditions, matches its own 8-bit address byte, and acknowledges each byte by pulling the open-drain data line low through an output enable. The surrounding chip reads the registers as one flat parallel bus. A one-cycle strobe with the register index marks every byte that is actually stored.

Transfers always use block framing. A write carries two leading bytes that the slave acknowledges and discards: the first is a command code and the second is a byte count. The data bytes then fill the registers from index 0 upward. A read first returns the value of the length register and then the registers from index 0 upward. The length register sets how many register bytes a read returns. The host does not choose this length.

Register 7 is a fixed identification byte. Register 8 is the read-length register. Every other implemented register is plain read/write storage.

Top module: `cfg_block_slave`

## Requirements
- R1: The slave acknowledges only the address bytes D2h (write) and D3h (read). For any other address byte it gives no acknowledge, and it keeps the data line released until the next start or stop.
- R2: In a write, the first two bytes after the address are acknowledged and change no register. The data bytes that follow are acknowledged and stored into registers 0, 1, 2 and upward, in order.
- R3: Each stored byte produces exactly one `wr_stb_o` pulse of one cycle, with `wr_idx_o` giving its register index. A discarded byte produces no pulse.
- R4: Register 7 always reads {4'b1001, REV_ID}, which is 93h with the default parameters. A write to it is acknowledged and has no effect.
- R5: Register 8 resets to 08h. A write of 00h to it stores 01h, so the register never holds 00h.
- R6: A write to an index at or above NUM_REGS is acknowledged and discarded. Reading such an index returns 00h.
- R7: A read returns the register 8 value first, then registers 0, 1, 2 and upward, each sent MSB first. The output enable on the data line changes only while SCL is low.
- R8: After the number of register bytes given by register 8, the slave releases the data line, so further bytes read as FFh.
- R9: After the host gives no acknowledge for a read byte, the slave drives nothing until the next start or stop.
- R10: A stop condition or a repeated start resets the register pointer, so the next transfer starts again at register 0.
- R11: After reset, registers 0–6 and 9 and above read 00h, register 7 reads 93h, register 8 reads 08h, and neither the data line nor the strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it must run much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| sda_oe_o | output | 1 | When 1, the pad pulls the data line low |
| regs_o | output | NUM_REGS*8 | Register file; register i is in bits [8i+7:8i] |
| wr_stb_o | output | 1 | One-cycle pulse for each stored byte |
| wr_idx_o | output | 8 | Index of the register written on the strobe |

## Verification
The slave is driven by a bus model that keeps a wired-AND data line. A sweep of sixteen address bytes next to D2h and D3h, differing in single bits and in the direction bit, separates exact address matching from partial matching. Full-bank writes and read-backs are repeated with four arithmetic data patterns; each pattern sets the length register to read one index past the bank. This separates the order of the stored data, the read-only identification byte, the 00h returned above the bank, and the release of the line after the length limit. Shorter sequences cut by a stop, by a repeated start, by an early NACK, or by writing 00h to the length register tell pointer reset, release after NACK and the 00h-to-01h substitution apart from plain storage.

// File: rtl/cbs_pkg.sv
// Shared types and constants for the block-transfer configuration slave.
// Assumes an 8-bit register pointer and a bank of more than nine registers.
package cbs_pkg;

    localparam int ID_REG  = 7;   // fixed identification byte
    localparam int CNT_REG = 8;   // read-length register

    localparam logic [3:0] VENDOR_CODE = 4'b1001;
    localparam logic [7:0] CNT_RESET   = 8'h08;

    // Serial link phase
    typedef enum logic [2:0] {
        LK_IDLE,   // no transfer addressed to this slave
        LK_RX,     // shifting in a byte from the host
        LK_RACK,   // driving acknowledge for a received byte
        LK_TX,     // shifting out a byte to the host
        LK_TACK,   // sampling the host acknowledge
        LK_HOLD    // silent until the next start or stop
    } link_st_e;

    // Role of the next received byte within a write
    typedef enum logic [1:0] {
        RK_ADDR,
        RK_CMD,
        RK_CNT,
        RK_DATA
    } rx_kind_e;

endpackage

// File: rtl/cbs_line_sampler.sv
// Line sampler: synchronises SCL and SDA into the system clock domain and
// reports clock edges and start/stop conditions as one-cycle pulses.
// Assumes SCL and SDA each stay stable for several system clocks.
module cbs_line_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_bit
);

    logic [1:0] scl_sync;
    logic [1:0] sda_sync;
    logic       scl_prev;
    logic       sda_prev;

    // Two-stage synchronisers plus one stage of history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sync <= 2'b11;
            sda_sync <= 2'b11;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[0], scl_i};
            sda_sync <= {sda_sync[0], sda_i};
            scl_prev <= scl_sync[1];
            sda_prev <= sda_sync[1];
        end
    end

    // Edge and bus-condition decode
    always_comb begin
        scl_rise  = scl_sync[1] & ~scl_prev;
        scl_fall  = ~scl_sync[1] & scl_prev;
        start_det = scl_sync[1] & scl_prev & sda_prev & ~sda_sync[1];
        stop_det  = scl_sync[1] & scl_prev & ~sda_prev & sda_sync[1];
        sda_bit   = sda_sync[1];
    end

endmodule

// File: rtl/cbs_link_fsm.sv
// Link controller: frames bytes, matches the address, drives acknowledge
// and read data, and keeps the register pointer.
// Assumes edge pulses from cbs_line_sampler. Data changes on SCL falls and
// is sampled on SCL rises.
module cbs_link_fsm
    import cbs_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'hD2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       sda_bit,
    input  logic [7:0] rd_byte,
    input  logic [7:0] cnt_byte,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data,
    output logic [7:0] ptr,
    output logic       quiet
);

    localparam logic [7:0] RD_ADDR = DEV_ADDR | 8'h01;

    link_st_e   st;
    rx_kind_e   kind;
    logic [3:0] bitn;
    logic [7:0] sh;
    logic [7:0] txsh;
    logic [7:0] rem;
    logic       rd_go;
    logic       host_ack;

    // Main link sequencer; stop and start take priority over every phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= LK_IDLE;
            kind     <= RK_ADDR;
            bitn     <= 4'd0;
            sh       <= 8'h00;
            txsh     <= 8'h00;
            rem      <= 8'h00;
            rd_go    <= 1'b0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= 8'h00;
            wr_data  <= 8'h00;
            ptr      <= 8'h00;
        end else begin
            wr_en <= 1'b0;
            if (stop_det) begin
                st     <= LK_IDLE;
                sda_oe <= 1'b0;
                ptr    <= 8'h00;
                rd_go  <= 1'b0;
            end else if (start_det) begin
                st     <= LK_RX;
                kind   <= RK_ADDR;
                bitn   <= 4'd0;
                sda_oe <= 1'b0;
                ptr    <= 8'h00;
                rd_go  <= 1'b0;
            end else begin
                case (st)
                    LK_RX: begin
                        if (scl_rise) begin
                            sh   <= {sh[6:0], sda_bit};
                            bitn <= bitn + 4'd1;
                        end else if (scl_fall && bitn == 4'd8) begin
                            sda_oe <= 1'b1;
                            st     <= LK_RACK;
                            case (kind)
                                RK_ADDR: begin
                                    if (sh == DEV_ADDR) begin
                                        kind <= RK_CMD;
                                    end else if (sh == RD_ADDR) begin
                                        rd_go <= 1'b1;
                                    end else begin
                                        sda_oe <= 1'b0;
                                        st     <= LK_HOLD;
                                    end
                                end
                                RK_CMD:  kind <= RK_CNT;
                                RK_CNT:  kind <= RK_DATA;
                                default: begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= ptr;
                                    wr_data <= sh;
                                    if (ptr != 8'hFF) ptr <= ptr + 8'd1;
                                end
                            endcase
                        end
                    end
                    LK_RACK: begin
                        if (scl_fall) begin
                            bitn <= 4'd0;
                            if (rd_go) begin
                                sda_oe <= ~cnt_byte[7];
                                txsh   <= {cnt_byte[6:0], 1'b0};
                                rem    <= cnt_byte;
                                st     <= LK_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= LK_RX;
                            end
                        end
                    end
                    LK_TX: begin
                        if (scl_rise) begin
                            bitn <= bitn + 4'd1;
                        end else if (scl_fall) begin
                            if (bitn == 4'd8) begin
                                sda_oe <= 1'b0;
                                st     <= LK_TACK;
                            end else begin
                                sda_oe <= ~txsh[7];
                                txsh   <= {txsh[6:0], 1'b0};
                            end
                        end
                    end
                    LK_TACK: begin
                        if (scl_rise) begin
                            host_ack <= ~sda_bit;
                        end else if (scl_fall) begin
                            bitn <= 4'd0;
                            if (host_ack && rem != 8'h00) begin
                                sda_oe <= ~rd_byte[7];
                                txsh   <= {rd_byte[6:0], 1'b0};
                                rem    <= rem - 8'd1;
                                if (ptr != 8'hFF) ptr <= ptr + 8'd1;
                                st     <= LK_TX;
                            end else begin
                                st <= LK_HOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Phases in which the slave must never pull the data line
    assign quiet = (st == LK_IDLE) || (st == LK_HOLD);

endmodule

// File: rtl/cbs_reg_bank.sv
// Register bank: one byte per index, with a fixed identification byte and a
// read-length register that never holds zero. Accepted writes raise a
// one-cycle strobe. Assumes NUM_REGS is greater than CNT_REG + 1.
module cbs_reg_bank
    import cbs_pkg::*;
#(
    parameter int         NUM_REGS = 12,
    parameter logic [3:0] REV_ID   = 4'h3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_idx,
    output logic [7:0]            rd_byte,
    output logic [7:0]            cnt_byte,
    output logic [NUM_REGS*8-1:0] regs_flat,
    output logic                  wr_stb,
    output logic [7:0]            stb_idx
);

    localparam logic [7:0] LAST_IDX = 8'(NUM_REGS - 1);
    localparam logic [7:0] ID_IDX   = 8'(ID_REG);

    logic accept;

    // A write lands only inside the bank and never on the identification byte
    assign accept = wr_en && (wr_idx <= LAST_IDX) && (wr_idx != ID_IDX);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] q;
        if (g == ID_REG) begin : g_id
            assign q = {VENDOR_CODE, REV_ID};
        end else if (g == CNT_REG) begin : g_cnt
            // Read-length register; zero is replaced by one
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= CNT_RESET;
                else if (accept && wr_idx == 8'(g))
                    q <= (wr_data == 8'h00) ? 8'h01 : wr_data;
            end
        end else begin : g_plain
            // Plain storage byte
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= 8'h00;
                else if (accept && wr_idx == 8'(g))
                    q <= wr_data;
            end
        end
        assign regs_flat[g*8 +: 8] = q;
    end

    // Read selection; indices past the bank read as zero
    always_comb begin
        rd_byte = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == 8'(i)) rd_byte = regs_flat[i*8 +: 8];
        end
    end

    assign cnt_byte = regs_flat[CNT_REG*8 +: 8];

    // Strobe that is aligned with the register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            stb_idx <= 8'h00;
        end else begin
            wr_stb  <= accept;
            stb_idx <= wr_idx;
        end
    end

endmodule

// File: rtl/cfg_block_slave.sv
// Top level of the block-transfer configuration slave: line sampler, link
// controller and register bank. Assumes the pad turns sda_oe_o into an
// open-drain pull-down and that clk runs much faster than SCL.
module cfg_block_slave
    import cbs_pkg::*;
#(
    parameter int         NUM_REGS = 12,
    parameter logic [7:0] DEV_ADDR = 8'hD2,
    parameter logic [3:0] REV_ID   = 4'h3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic                  wr_stb_o,
    output logic [7:0]            wr_idx_o
);

    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic       sda_bit;
    logic       wr_en;
    logic [7:0] wr_idx;
    logic [7:0] wr_data;
    logic [7:0] ptr;
    logic [7:0] rd_byte;
    logic [7:0] cnt_byte;
    logic       link_quiet;

    cbs_line_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit)
    );

    cbs_link_fsm #(
        .DEV_ADDR (DEV_ADDR)
    ) u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_bit   (sda_bit),
        .rd_byte   (rd_byte),
        .cnt_byte  (cnt_byte),
        .sda_oe    (sda_oe_o),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .quiet     (link_quiet)
    );

    cbs_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .REV_ID   (REV_ID)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx    (ptr),
        .rd_byte   (rd_byte),
        .cnt_byte  (cnt_byte),
        .regs_flat (regs_o),
        .wr_stb    (wr_stb_o),
        .stb_idx   (wr_idx_o)
    );

endmodule

// File: rtl/cfg_block_slave_chk.sv
// Checker for cfg_block_slave: relates the data-line enable, the strobe and
// the length register over time. It is attached with the bind below.
module cfg_block_slave_chk #(
    parameter int NUM_REGS = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe_o,
    input logic       wr_stb_o,
    input logic [7:0] wr_idx_o,
    input logic [7:0] cnt_reg,
    input logic       link_quiet
);

    localparam logic [7:0] LAST_IDX = 8'(NUM_REGS - 1);

    // R7: the data-line enable only changes while SCL is low
    a_r7_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> !scl_i);

    // R3: the strobe lasts a single cycle
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o);

    // R3, R4, R6: the strobe names only writable, implemented registers
    a_r3_strobe_legal: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |-> (wr_idx_o <= LAST_IDX && wr_idx_o != 8'd7));

    // R5: the read-length register never holds zero
    a_r5_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_reg != 8'h00);

    // R1, R9: idle and silent phases never pull the line
    a_r9_quiet_released: assert property (@(posedge clk) disable iff (!rst_n)
        link_quiet |-> !sda_oe_o);

endmodule

bind cfg_block_slave cfg_block_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .wr_stb_o   (wr_stb_o),
    .wr_idx_o   (wr_idx_o),
    .cnt_reg    (regs_o[8*8 +: 8]),
    .link_quiet (link_quiet)
);

// File: tb/cfg_block_slave_tb_top.sv
// Bench for cfg_block_slave: a bus model on a wired-AND data line, with a
// register model computed from the requirements.
module cfg_block_slave_tb_top;

    localparam int NUM = 12;
    localparam int Q   = 8;   // system clocks per quarter SCL bit

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             scl = 1'b1;
    logic             sda_m = 1'b1;
    logic             sda_oe;
    logic             sda_line;
    logic [NUM*8-1:0] regs;
    logic             wr_stb;
    logic [7:0]       wr_idx;

    int         checks = 0;
    int         fails = 0;
    int         exp_stb = 0;
    int         seen_stb = 0;
    logic [7:0] exp_r [NUM];
    logic [7:0] wdat [32];

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    cfg_block_slave #(.NUM_REGS(NUM)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .regs_o   (regs),
        .wr_stb_o (wr_stb),
        .wr_idx_o (wr_idx)
    );

    always @(posedge clk) if (rst_n && wr_stb) seen_stb++;

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic drv, output logic smp);
        wq(Q); sda_m = drv;
        wq(Q); scl = 1'b1;
        wq(Q); smp = sda_line;
        wq(Q); scl = 1'b0;
    endtask

    task automatic start_c();
        if (!scl) begin
            wq(Q); sda_m = 1'b1;
            wq(Q); scl = 1'b1;
            wq(2*Q);
        end
        sda_m = 1'b0;
        wq(2*Q); scl = 1'b0;
    endtask

    task automatic stop_c();
        wq(Q); sda_m = 1'b0;
        wq(Q); scl = 1'b1;
        wq(2*Q); sda_m = 1'b1;
        wq(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            b[i] = s;
        end
        clk_bit(~give_ack, s);
    endtask

    task automatic model_write(input int i, input logic [7:0] d);
        if (i < NUM && i != 7) begin
            exp_r[i] = (i == 8 && d == 8'h00) ? 8'h01 : d;
            exp_stb++;
        end
    endtask

    function automatic logic [7:0] exp_data(input int k);
        if (k >= int'(exp_r[8])) return 8'hFF;
        if (k >= NUM) return 8'h00;
        return exp_r[k];
    endfunction

    task automatic check_bank(input string req);
        for (int i = 0; i < NUM; i++) chk(req, int'(regs[i*8 +: 8]), int'(exp_r[i]));
        chk({req, " R3 strobe count"}, seen_stb, exp_stb);
    endtask

    // Block write of n data bytes
    task automatic write_seq(input int n, input logic stop_after);
        logic a;
        start_c();
        send_byte(8'hD2, a); chk("R1 write address ack", int'(a), 1);
        send_byte(8'hA5, a); chk("R2 command ack", int'(a), 1);
        send_byte(8'(n), a); chk("R2 count ack", int'(a), 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wdat[i], a);
            chk(i < NUM ? "R2 data ack" : "R6 beyond-bank ack", int'(a), 1);
            model_write(i, wdat[i]);
        end
        if (stop_after) stop_c();
    endtask

    // Block read: length byte, then n data bytes, the last one NACKed
    task automatic read_seq(input int n);
        logic       a;
        logic [7:0] v;
        start_c();
        send_byte(8'hD3, a); chk("R1 read address ack", int'(a), 1);
        recv_byte(n > 0, v); chk("R7 length byte first", int'(v), int'(exp_r[8]));
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, v);
            chk(k >= int'(exp_r[8]) ? "R8 released past length" :
                (k >= NUM ? "R6 beyond-bank reads 00" : "R7 read order"),
                int'(v), int'(exp_data(k)));
        end
        stop_c();
    endtask

    initial begin
        logic       a;
        logic [7:0] v;
        logic [7:0] alist [16] = '{8'hD2, 8'hD3, 8'hD0, 8'hD1, 8'hD6, 8'hD7,
                                   8'h52, 8'h53, 8'h92, 8'h93, 8'hF2, 8'hF3,
                                   8'hC2, 8'hC3, 8'h00, 8'hFF};
        for (int i = 0; i < NUM; i++) exp_r[i] = 8'h00;
        exp_r[7] = 8'h93;
        exp_r[8] = 8'h08;
        wq(10);
        rst_n = 1'b1;
        wq(4);

        // R11 reset state
        check_bank("R11 reset value");
        chk("R11 line released", int'(sda_oe), 0);
        chk("R11 no strobe", int'(wr_stb), 0);

        // R1 address sweep
        foreach (alist[j]) begin
            start_c();
            send_byte(alist[j], a);
            chk("R1 address match", int'(a), int'(alist[j] == 8'hD2 || alist[j] == 8'hD3));
            if (alist[j] == 8'hD3) begin
                recv_byte(1'b0, v);
                chk("R7 length byte", int'(v), int'(exp_r[8]));
            end else if (alist[j] != 8'hD2) begin
                send_byte(8'h00, a);
                chk("R1 silent after mismatch", int'(a), 0);
            end
            stop_c();
        end

        // R2 R4 R6: full write past the bank, length register = 5
        for (int i = 0; i < NUM + 3; i++) wdat[i] = 8'(i * 17 + 3);
        wdat[8] = 8'h05;
        write_seq(NUM + 3, 1'b1);
        check_bank("R2 R4 R6 full write");
        chk("R4 id byte", int'(regs[7*8 +: 8]), 8'h93);

        // R7 R8: read two bytes past the limit
        read_seq(7);

        // R5: zero into the length register becomes one
        for (int i = 0; i < 9; i++) wdat[i] = 8'(8'hC0 + i);
        wdat[8] = 8'h00;
        write_seq(9, 1'b1);
        chk("R5 zero stored as one", int'(regs[8*8 +: 8]), 1);
        read_seq(2);

        // Sweeps over four data patterns, length reaching one past the bank
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < NUM + 2; i++) wdat[i] = 8'((s * 73 + i * 29 + 5) ^ (s << 6));
            wdat[8] = 8'(NUM + 1);
            write_seq(NUM + 2, 1'b1);
            check_bank("R2 pattern sweep");
            read_seq(NUM + 2);
        end

        // R10: stop resets the pointer
        wdat[0] = 8'h11; wdat[1] = 8'h22; wdat[2] = 8'h33;
        write_seq(3, 1'b1);
        wdat[0] = 8'h44; wdat[1] = 8'h55;
        write_seq(2, 1'b1);
        chk("R10 stop restarts at 0", int'(regs[0 +: 8]), 8'h44);
        chk("R10 stop keeps reg2", int'(regs[2*8 +: 8]), 8'h33);

        // R10: repeated start resets the pointer
        for (int i = 0; i < 4; i++) wdat[i] = 8'(8'h61 + i);
        write_seq(4, 1'b0);
        wdat[0] = 8'h70;
        write_seq(1, 1'b0);
        chk("R10 repeated start restarts at 0", int'(regs[0 +: 8]), 8'h70);
        chk("R10 repeated start keeps reg1", int'(regs[1*8 +: 8]), 8'h62);
        read_seq(3);

        // R9: NACK releases the line until stop
        for (int i = 0; i < 9; i++) wdat[i] = exp_r[i];
        wdat[8] = 8'h06;
        write_seq(9, 1'b1);
        start_c();
        send_byte(8'hD3, a); chk("R1 read address ack", int'(a), 1);
        recv_byte(1'b1, v); chk("R7 length byte", int'(v), 6);
        recv_byte(1'b1, v); chk("R7 reg0", int'(v), int'(exp_r[0]));
        recv_byte(1'b0, v); chk("R7 reg1", int'(v), int'(exp_r[1]));
        recv_byte(1'b1, v); chk("R9 silent after NACK", int'(v), 8'hFF);
        chk("R9 line released", int'(sda_oe), 0);
        stop_c();
        read_seq(1);

        check_bank("R3 final bank");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule